// File: doc/BRIEF.md
# Bus Fault Register Capture

This block holds a 16-bit sticky fault register for a processor's bus controller. Three active-low error inputs come from external logic: memory protection, memory parity and address decode. They are sampled once per bus cycle, on the clock edge where the bus-busy qualifier drops. Two cycle-type inputs route each error to its bit: one tells a CPU cycle from a non-CPU cycle, the other tells a memory cycle from an I/O cycle. Two asynchronous system fault lines are synchronized and edge-detected, and each rising edge sets its assigned bits.

Software reads the register directly. It clears bits by presenting a one-hot or multi-bit mask with a clear strobe. A fault that arrives in the same cycle as its clear still lands. Two summary outputs group the bits into unrecoverable and major classes. The clear port is a plain strobe with no back-pressure: every strobe takes effect at the next clock edge.

Top module: `bus_fault_capture`

## Requirements
- R1: While `rst_n` is low, the register is all zeros and both summary outputs are low.
- R2: A bus cycle ends at a rising clock edge where `bus_busy` is 0 and was 1 at the previous edge. If `prot_err_n` is 0 at that edge, bit 0 is set when `cyc_cpu` is 1 and bit 1 is set when `cyc_cpu` is 0.
- R3: If `par_err_n` is 0 at a cycle-ending edge, bit 2 is set.
- R4: If `addr_err_n` is 0 at a cycle-ending edge, bit 5 is set when `cyc_io` is 0 (memory cycle) and bit 8 is set when `cyc_io` is 1 (I/O cycle).
- R5: The three error inputs have no effect at any edge that does not end a bus cycle, whether `bus_busy` is held high or held low.
- R6: A rising edge on `sys_fault0` sets bit 7. If the line is first seen high at clock edge k, the bit shows after edge k+2 and not before. A line that stays high sets the bit only once, so clearing the bit while the line stays high leaves it clear.
- R7: A rising edge on `sys_fault1` sets both bit 13 and bit 15, with the same timing as R6.
- R8: Set bits hold until cleared. At an edge where `clr_en` is 1, each bit with a 1 in `clr_mask` is cleared, and bits with a 0 are kept.
- R9: When a bit is set and cleared at the same edge, it ends up set.
- R10: `unrecov` is the OR of bits 13 and 15. `major` is the OR of bits 0, 1, 2, 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| cyc_cpu | input | 1 | 1 = CPU bus cycle, 0 = non-CPU cycle |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| prot_err_n | input | 1 | Memory-protect error, active low |
| par_err_n | input | 1 | Memory parity error, active low |
| addr_err_n | input | 1 | External address error, active low |
| sys_fault0 | input | 1 | Asynchronous system fault line 0 |
| sys_fault1 | input | 1 | Asynchronous system fault line 1 |
| clr_en | input | 1 | Clear strobe |
| clr_mask | input | 16 | Bits to clear when `clr_en` is high |
| fault_q | output | 16 | Fault register contents |
| unrecov | output | 1 | Unrecoverable error summary |
| major | output | 1 | Major error summary |

## Verification
Two functions can land on the same edge: a bus-cycle error or system-fault edge setting a bit, and a software clear aimed at that same bit. Directed sequences drive a cycle-ending edge with a parity error and, at the same time, a clear mask covering bit 2. The bench expects the bit to survive, while a second bit cleared at that edge drops. The random phase drives independent clear strobes against random bus cycles and fault toggles. It judges every edge against a bench model in which setting wins.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int FLT_W        = 16;
  localparam int NUM_SYS      = 2;
  localparam int SYNC_STAGES  = 2;

  localparam int BIT_PROT_CPU = 0;
  localparam int BIT_PROT_ALT = 1;
  localparam int BIT_PARITY   = 2;
  localparam int BIT_ADDR_MEM = 5;
  localparam int BIT_SYS0     = 7;
  localparam int BIT_ADDR_IO  = 8;
  localparam int BIT_SYS1_LO  = 13;
  localparam int BIT_SYS1_HI  = 15;

  localparam logic [FLT_W-1:0] ONE = FLT_W'(1);

  localparam logic [FLT_W-1:0] UNRECOV_MASK =
    (ONE << BIT_SYS1_LO) | (ONE << BIT_SYS1_HI);

  localparam logic [FLT_W-1:0] MAJOR_MASK =
    (ONE << BIT_PROT_CPU) | (ONE << BIT_PROT_ALT) | (ONE << BIT_PARITY) |
    (ONE << BIT_ADDR_MEM) | (ONE << BIT_SYS0) | (ONE << BIT_ADDR_IO);

  // bits set by each system fault line, indexed by line number
  function automatic logic [FLT_W-1:0] sys_bits(input int line);
    logic [FLT_W-1:0] m;
    m = '0;
    if (line == 0) m = ONE << BIT_SYS0;
    else           m = (ONE << BIT_SYS1_LO) | (ONE << BIT_SYS1_HI);
    return m;
  endfunction

  typedef struct packed {
    logic prot_n;
    logic par_n;
    logic addr_n;
    logic is_cpu;
    logic is_io;
  } bus_err_t;
endpackage

// File: rtl/bfc_sync_edge.sv
module bfc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bfc_bus_sampler.sv
module bfc_bus_sampler
  import bfc_pkg::*;
#(
  parameter int W = FLT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_busy,
  input  bus_err_t     errs,
  output logic         cycle_end,
  output logic [W-1:0] set_mask
);
  logic busy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_d <= 1'b0;
    else        busy_d <= bus_busy;
  end

  assign cycle_end = busy_d & ~bus_busy;

  always_comb begin
    set_mask = '0;
    if (cycle_end) begin
      if (!errs.prot_n) begin
        if (errs.is_cpu) set_mask[BIT_PROT_CPU] = 1'b1;
        else             set_mask[BIT_PROT_ALT] = 1'b1;
      end
      if (!errs.par_n) set_mask[BIT_PARITY] = 1'b1;
      if (!errs.addr_n) begin
        if (errs.is_io) set_mask[BIT_ADDR_IO]  = 1'b1;
        else            set_mask[BIT_ADDR_MEM] = 1'b1;
      end
    end
  end

  // R5
  quiet_between_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_d && !bus_busy) |-> (set_mask == '0));
endmodule

// File: rtl/bfc_fault_reg.sv
module bfc_fault_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_eff) | set_mask;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R8
    sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !(clr_en && clr_mask[i])) |=> q[i]);
    // R8
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_mask[i] && !set_mask[i]) |=> !q[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> q[i]);
  end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             cyc_cpu,
  input  logic             cyc_io,
  input  logic             prot_err_n,
  input  logic             par_err_n,
  input  logic             addr_err_n,
  input  logic             sys_fault0,
  input  logic             sys_fault1,
  input  logic             clr_en,
  input  logic [FLT_W-1:0] clr_mask,
  output logic [FLT_W-1:0] fault_q,
  output logic             unrecov,
  output logic             major
);
  bus_err_t             errs;
  logic                 cycle_end;
  logic [FLT_W-1:0]     bus_set;
  logic [NUM_SYS-1:0]   sys_in;
  logic [NUM_SYS-1:0]   sys_rise;
  logic [FLT_W-1:0]     sys_set;
  logic [FLT_W-1:0]     set_all;

  assign errs   = '{prot_n: prot_err_n, par_n: par_err_n, addr_n: addr_err_n,
                    is_cpu: cyc_cpu, is_io: cyc_io};
  assign sys_in = {sys_fault1, sys_fault0};

  bfc_bus_sampler #(.W(FLT_W)) u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_busy  (bus_busy),
    .errs      (errs),
    .cycle_end (cycle_end),
    .set_mask  (bus_set)
  );

  for (genvar s = 0; s < NUM_SYS; s++) begin : g_sys
    bfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sys_in[s]),
      .rise     (sys_rise[s])
    );
  end

  always_comb begin
    sys_set = '0;
    for (int s = 0; s < NUM_SYS; s++)
      if (sys_rise[s]) sys_set |= sys_bits(s);
  end

  assign set_all = bus_set | sys_set;

  bfc_fault_reg #(.W(FLT_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_all),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .q        (fault_q)
  );

  assign unrecov = |(fault_q & UNRECOV_MASK);
  assign major   = |(fault_q & MAJOR_MASK);

  // R2
  prot_cpu_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !prot_err_n && cyc_cpu) |=> fault_q[BIT_PROT_CPU]);
  // R4
  addr_io_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !addr_err_n && cyc_io) |=> fault_q[BIT_ADDR_IO]);
  // R7
  sys1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q[BIT_SYS1_HI]) |-> fault_q[BIT_SYS1_LO]);
  // R8
  no_cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_end && sys_rise == '0 && !clr_en) |=> $stable(fault_q));
endmodule

// File: tb/sim_bus_fault_capture.sv
`timescale 1ns/1ps
module sim_bus_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_busy = 1'b0, cyc_cpu = 1'b0, cyc_io = 1'b0;
  logic        prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
  logic        sys_fault0 = 1'b0, sys_fault1 = 1'b0;
  logic        clr_en = 1'b0;
  logic [15:0] clr_mask = '0;
  logic [15:0] fault_q;
  logic        unrecov, major;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic        m_busy_d;
  logic [1:0]  m_s1, m_s2, m_s3;
  logic [15:0] m_q;

  always #2.5 clk = ~clk;

  bus_fault_capture u0 (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .cyc_cpu(cyc_cpu),
    .cyc_io(cyc_io), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
    .addr_err_n(addr_err_n), .sys_fault0(sys_fault0), .sys_fault1(sys_fault1),
    .clr_en(clr_en), .clr_mask(clr_mask), .fault_q(fault_q),
    .unrecov(unrecov), .major(major)
  );

  function automatic logic exp_unrecov(input logic [15:0] q);
    return q[13] | q[15];
  endfunction

  function automatic logic exp_major(input logic [15:0] q);
    return q[0] | q[1] | q[2] | q[5] | q[7] | q[8];
  endfunction

  function automatic logic [15:0] exp_set(
    input logic busy_d, input logic busy, input logic cpu, input logic io,
    input logic p_n, input logic y_n, input logic a_n,
    input logic [1:0] s2, input logic [1:0] s3);
    logic [15:0] m;
    m = '0;
    if (busy_d && !busy) begin
      if (!p_n) m |= cpu ? 16'h0001 : 16'h0002;
      if (!y_n) m |= 16'h0004;
      if (!a_n) m |= io ? 16'h0100 : 16'h0020;
    end
    if (s2[0] && !s3[0]) m |= 16'h0080;
    if (s2[1] && !s3[1]) m |= 16'hA000;
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one clock edge, update model, compare at the falling edge
  task automatic tick();
    logic [15:0] s;
    @(posedge clk);
    if (!rst_n) begin
      m_busy_d = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_q = 0;
    end else begin
      s = exp_set(m_busy_d, bus_busy, cyc_cpu, cyc_io, prot_err_n, par_err_n,
                  addr_err_n, m_s2, m_s3);
      m_q = (m_q & ~(clr_en ? clr_mask : 16'h0)) | s;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {sys_fault1, sys_fault0};
      m_busy_d = bus_busy;
    end
    @(negedge clk);
    check("R8 model", fault_q, m_q);
    check("R10 summary", {14'd0, unrecov, major}, {14'd0, exp_unrecov(m_q), exp_major(m_q)});
  endtask

  task automatic idle();
    bus_busy = 0; prot_err_n = 1; par_err_n = 1; addr_err_n = 1;
    clr_en = 0; clr_mask = '0;
  endtask

  task automatic clear_all();
    idle(); clr_en = 1; clr_mask = 16'hFFFF; tick(); idle();
  endtask

  // one bus cycle ending with the given errors
  task automatic bus_cycle(input logic cpu, input logic io,
                           input logic p_n, input logic y_n, input logic a_n);
    idle(); bus_busy = 1; cyc_cpu = cpu; cyc_io = io; tick();
    bus_busy = 0; prot_err_n = p_n; par_err_n = y_n; addr_err_n = a_n; tick();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hBEEF));
    m_busy_d = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_q = 0;
    idle();
    tick(); tick();
    // R1: reset state
    check("R1", fault_q, 16'h0000);
    check("R1 summary", {14'd0, unrecov, major}, 16'h0000);
    @(negedge clk); rst_n = 1;
    tick();

    // R2: protect error, CPU then non-CPU
    bus_cycle(1, 0, 0, 1, 1);
    check("R2 cpu", fault_q, 16'h0001);
    check("R10 major", {15'd0, major}, 16'h0001);
    clear_all();
    check("R8 clear", fault_q, 16'h0000);
    bus_cycle(0, 0, 0, 1, 1);
    check("R2 non-cpu", fault_q, 16'h0002);
    clear_all();

    // R3 parity, R4 address memory / io
    bus_cycle(1, 0, 1, 0, 1);
    check("R3", fault_q, 16'h0004);
    clear_all();
    bus_cycle(1, 0, 1, 1, 0);
    check("R4 memory", fault_q, 16'h0020);
    clear_all();
    bus_cycle(1, 1, 1, 1, 0);
    check("R4 io", fault_q, 16'h0100);

    // R8: partial clear keeps other bits
    bus_cycle(1, 0, 1, 0, 1);
    clr_en = 1; clr_mask = 16'h0100; tick(); idle();
    check("R8 partial", fault_q, 16'h0004);
    clear_all();

    // R5: errors with busy held high, then held low
    bus_busy = 1; prot_err_n = 0; par_err_n = 0; addr_err_n = 0; tick();
    tick(); tick();
    check("R5 busy high", fault_q, 16'h0000);
    idle(); tick();   // this edge ends the cycle with no errors
    prot_err_n = 0; par_err_n = 0; addr_err_n = 0; tick(); tick();
    check("R5 busy low", fault_q, 16'h0000);
    idle();

    // R6: sys_fault0 timing and single set
    sys_fault0 = 1; tick(); tick();
    check("R6 early", fault_q, 16'h0000);
    tick();
    check("R6 set", fault_q, 16'h0080);
    clear_all(); tick(); tick(); tick();
    check("R6 held high", fault_q, 16'h0000);
    sys_fault0 = 0; tick(); tick(); tick();

    // R7: sys_fault1 sets two bits
    sys_fault1 = 1; tick(); tick(); tick();
    check("R7", fault_q, 16'hA000);
    check("R10 unrecov", {15'd0, unrecov}, 16'h0001);
    sys_fault1 = 0;
    clr_en = 1; clr_mask = 16'h8000; tick(); idle();
    check("R10 partial unrecov", {15'd0, unrecov}, 16'h0001);
    clear_all(); tick(); tick();

    // R9: set and clear of bit 2 at the same edge, bit 0 cleared there too
    bus_cycle(1, 0, 0, 1, 1);
    bus_busy = 1; tick();
    bus_busy = 0; par_err_n = 0; clr_en = 1; clr_mask = 16'h0005; tick(); idle();
    check("R9 set wins", fault_q, 16'h0004);
    clear_all();

    // random phase, checked every edge against the model
    for (int n = 0; n < 3000; n++) begin
      bus_busy   = ($urandom % 3) != 0;
      cyc_cpu    = $urandom % 2;
      cyc_io     = $urandom % 2;
      prot_err_n = ($urandom % 4) != 0;
      par_err_n  = ($urandom % 4) != 0;
      addr_err_n = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) sys_fault0 = ~sys_fault0;
      if ($urandom % 8 == 0) sys_fault1 = ~sys_fault1;
      clr_en     = ($urandom % 5) == 0;
      clr_mask   = 16'($urandom);
      if (n == 1500) rst_n = 0;
      if (n == 1503) begin
        check("R1 mid-run", fault_q, 16'h0000);
        rst_n = 1;
      end
      tick();
    end
    idle();
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule